// File: doc/BRIEF.md
# Seven-Channel DMA Register Bank

This block is the software-visible register bank of a DMA controller with seven channels. Each channel has a 16-byte window that holds a 32-bit base address, a 32-bit block control word and a 32-bit channel control word. Two global words follow the channel windows. The first is the primary control word, which holds a priority and a master enable for every channel. The second is the interrupt control word. That word is not stored here: reads and writes to it pass straight through to a separate interrupt unit.

The block drives a few signals to the transfer engine: each channel's busy bit, its master enable, its priority, and a combined "may run" flag. The engine returns a one-cycle completion pulse per channel and a one-cycle bus-error pulse per channel. Either pulse makes the bank clear that channel's busy bit. A bus error is also passed on to the interrupt unit. The bus port is a plain synchronous port with valid, write, a byte offset and write data. Read data appears on the cycle after the request.

Top module: `dma_chan_regs`

## Requirements
- R1: A byte offset with bits [1:0] equal to zero, bits [6:4] equal to n below 7, and bits [3:0] equal to 0x0, 0x4 or 0x8 selects channel n's base address, block control or channel control word. Each of these is a 32-bit read/write register.
- R2: Offset 0x70 is the primary control word, a 32-bit read/write register. Offset 0x74 is forwarded to the interrupt unit. A write there raises `ic_we` in the same cycle with `ic_wdata` equal to the bus write data. A read there returns `ic_rdata`.
- R3: After reset, every channel word reads zero and the primary control word reads 0x07654321.
- R4: Channel n owns nibble n of the primary control word. Bits [4n+2:4n] appear on `ch_prio[3n+2:3n]` and bit 4n+3 appears on `ch_en[n]`.
- R5: `ch_busy[n]` equals bit 24 of channel n's control word. `ch_go[n]` is high exactly when both `ch_en[n]` and `ch_busy[n]` are high.
- R6: A `done_pulse[n]` clears bit 24 of channel n's control word and leaves its other bits unchanged. When it arrives in the same cycle as a bus write to that word, the write lands and bit 24 still ends up clear.
- R7: A `berr_pulse[n]` clears bit 24 of channel n's control word. `ic_berr[n]` is high for exactly the following cycle.
- R8: Offsets 0x0C inside a channel window, 0x78, 0x7C and any offset with bits [1:0] non-zero read as zero. Writes to them change no register.
- R9: `bus_rdata` holds the selected word in the cycle after an accepted read. It is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| ic_we | output | 1 | Write strobe to the interrupt unit |
| ic_wdata | output | 32 | Write data to the interrupt unit |
| ic_rdata | input | 32 | Current interrupt control word |
| done_pulse | input | 7 | Per-channel transfer completion |
| berr_pulse | input | 7 | Per-channel bus error |
| ic_berr | output | 7 | Bus-error indication to the interrupt unit |
| ch_busy | output | 7 | Per-channel busy bit |
| ch_en | output | 7 | Per-channel master enable |
| ch_prio | output | 21 | Per-channel 3-bit priority |
| ch_go | output | 7 | Enable and busy both set |

## Verification
The address map is swept in full, every word offset from 0x00 to 0x7C, in three passes. The first pass reads the reset image. The second writes a distinct value to each offset, and the third reads them all back. A wrong channel index, a swapped slot or an unmapped offset that stores data each shows up as a mismatch at a specific offset. Misaligned offsets are tried as well, so that dropping the low-bit check is caught. Completion and bus-error pulses are applied to sets of busy channels and to channels that are idle. One completion pulse coincides with a write, which shows whether the hardware clear takes priority. Several patterns of master enables are crossed with busy patterns to separate `ch_go` from either bit alone.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned OFF_W   = 7;
    localparam int unsigned CHIDX_W = 3;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_BASE,
        RK_BLOCK,
        RK_CTRL,
        RK_PRIMARY,
        RK_IRQ
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [CHIDX_W-1:0]    chan;
    } reg_sel_t;

    localparam logic [3:0]       SLOT_BASE   = 4'h0;
    localparam logic [3:0]       SLOT_BLOCK  = 4'h4;
    localparam logic [3:0]       SLOT_CTRL   = 4'h8;
    localparam logic [OFF_W-1:0] OFF_PRIMARY = 7'h70;
    localparam logic [OFF_W-1:0] OFF_IRQ     = 7'h74;

    function automatic reg_sel_t decode_offset(input logic [OFF_W-1:0] off,
                                               input int unsigned      nch);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.chan = off[OFF_W-1:4];
        if (off[1:0] == 2'b00) begin
            if (off == OFF_PRIMARY) begin
                s.kind = RK_PRIMARY;
            end else if (off == OFF_IRQ) begin
                s.kind = RK_IRQ;
            end else if (int'(off[OFF_W-1:4]) < int'(nch)) begin
                case (off[3:0])
                    SLOT_BASE:  s.kind = RK_BASE;
                    SLOT_BLOCK: s.kind = RK_BLOCK;
                    SLOT_CTRL:  s.kind = RK_CTRL;
                    default:    s.kind = RK_NONE;
                endcase
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/dmar_decode.sv
module dmar_decode
    import dmar_pkg::*;
#(
    parameter int unsigned NUM_CH = 7
) (
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [OFF_W-1:0] bus_addr,
    output reg_sel_t         sel,
    output logic [NUM_CH-1:0] we_base,
    output logic [NUM_CH-1:0] we_block,
    output logic [NUM_CH-1:0] we_ctrl,
    output logic             we_primary,
    output logic             we_irq
);

    logic wr;

    always_comb begin
        sel = decode_offset(bus_addr, NUM_CH);
        wr  = bus_valid && bus_write;
        we_primary = wr && (sel.kind == RK_PRIMARY);
        we_irq     = wr && (sel.kind == RK_IRQ);
        for (int i = 0; i < NUM_CH; i++) begin
            we_base[i]  = wr && (sel.kind == RK_BASE)  && (int'(sel.chan) == i);
            we_block[i] = wr && (sel.kind == RK_BLOCK) && (int'(sel.chan) == i);
            we_ctrl[i]  = wr && (sel.kind == RK_CTRL)  && (int'(sel.chan) == i);
        end
    end

    always_comb begin
        AST_ONE_STROBE: assert ($onehot0({we_base, we_block, we_ctrl, we_primary, we_irq})); // R8
    end

endmodule

// File: rtl/dmar_chan.sv
module dmar_chan
    import dmar_pkg::*;
#(
    parameter int unsigned BUSY_BIT = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_base,
    input  logic              we_block,
    input  logic              we_ctrl,
    input  logic [WORD_W-1:0] wdata,
    input  logic              done_i,
    input  logic              berr_i,
    output logic [WORD_W-1:0] base_q,
    output logic [WORD_W-1:0] block_q,
    output logic [WORD_W-1:0] ctrl_q
);

    logic [WORD_W-1:0] ctrl_d;

    always_comb begin
        ctrl_d = we_ctrl ? wdata : ctrl_q;
        if (done_i || berr_i) ctrl_d[BUSY_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            block_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (we_base)  base_q  <= wdata;
            if (we_block) block_q <= wdata;
            ctrl_q <= ctrl_d;
        end
    end

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !ctrl_q[BUSY_BIT]); // R6
    AST_BERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        berr_i |=> !ctrl_q[BUSY_BIT]); // R7
    AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q[BUSY_BIT]) |-> $past(we_ctrl && wdata[BUSY_BIT])); // R5
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we_base |=> $stable(base_q)); // R1

endmodule

// File: rtl/dmar_primary.sv
module dmar_primary
    import dmar_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_VAL = 32'h0765_4321
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] pcr_q
);

    always_ff @(posedge clk) begin
        if (rst)     pcr_q <= RESET_VAL;
        else if (we) pcr_q <= wdata;
    end

    AST_PRIMARY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(pcr_q)); // R2

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmar_pkg::*;
#(
    parameter int unsigned NUM_CH   = 7,
    parameter int unsigned PRIO_W   = 3,
    parameter int unsigned BUSY_BIT = 24,
    parameter logic [31:0] PCR_INIT = 32'h0765_4321
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [6:0]               bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     ic_we,
    output logic [31:0]              ic_wdata,
    input  logic [31:0]              ic_rdata,
    input  logic [NUM_CH-1:0]        done_pulse,
    input  logic [NUM_CH-1:0]        berr_pulse,
    output logic [NUM_CH-1:0]        ic_berr,
    output logic [NUM_CH-1:0]        ch_busy,
    output logic [NUM_CH-1:0]        ch_en,
    output logic [NUM_CH*PRIO_W-1:0] ch_prio,
    output logic [NUM_CH-1:0]        ch_go
);

    localparam int unsigned NIB_W = PRIO_W + 1;

    reg_sel_t          sel;
    logic [NUM_CH-1:0] we_base, we_block, we_ctrl;
    logic              we_primary;
    logic [WORD_W-1:0] pcr_q;
    logic [WORD_W-1:0] base_q  [NUM_CH];
    logic [WORD_W-1:0] block_q [NUM_CH];
    logic [WORD_W-1:0] ctrl_q  [NUM_CH];
    logic [WORD_W-1:0] rd_mux;
    logic              rd_req;

    dmar_decode #(.NUM_CH(NUM_CH)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .sel       (sel),
        .we_base   (we_base),
        .we_block  (we_block),
        .we_ctrl   (we_ctrl),
        .we_primary(we_primary),
        .we_irq    (ic_we)
    );

    dmar_primary #(.RESET_VAL(PCR_INIT)) u_primary (
        .clk  (clk),
        .rst  (rst),
        .we   (we_primary),
        .wdata(bus_wdata),
        .pcr_q(pcr_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dmar_chan #(.BUSY_BIT(BUSY_BIT)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .we_base (we_base[i]),
            .we_block(we_block[i]),
            .we_ctrl (we_ctrl[i]),
            .wdata   (bus_wdata),
            .done_i  (done_pulse[i]),
            .berr_i  (berr_pulse[i]),
            .base_q  (base_q[i]),
            .block_q (block_q[i]),
            .ctrl_q  (ctrl_q[i])
        );
        assign ch_busy[i]               = ctrl_q[i][BUSY_BIT];
        assign ch_en[i]                 = pcr_q[NIB_W*i+PRIO_W];
        assign ch_prio[PRIO_W*i+:PRIO_W] = pcr_q[NIB_W*i+:PRIO_W];
        assign ch_go[i]                 = ch_busy[i] && ch_en[i];
    end

    assign ic_wdata = bus_wdata;
    assign rd_req   = bus_valid && !bus_write;

    always_comb begin
        case (sel.kind)
            RK_BASE:    rd_mux = base_q[sel.chan];
            RK_BLOCK:   rd_mux = block_q[sel.chan];
            RK_CTRL:    rd_mux = ctrl_q[sel.chan];
            RK_PRIMARY: rd_mux = pcr_q;
            RK_IRQ:     rd_mux = ic_rdata;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            ic_berr   <= '0;
        end else begin
            bus_rdata <= rd_req ? rd_mux : '0;
            ic_berr   <= berr_pulse;
        end
    end

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> (bus_rdata == '0)); // R9
    AST_BERR_FWD: assert property (@(posedge clk) disable iff (rst)
        (|berr_pulse) |=> (|ic_berr)); // R7
    AST_GO_SUBSET: assert property (@(posedge clk) disable iff (rst)
        (ch_go & ~ch_en) == '0); // R5

endmodule

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;

    localparam int NCH = 7;
    localparam int BB  = 24;
    localparam logic [31:0] IRQ_WORD = 32'h5A3C_0F81;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ic_we;
    logic [31:0] ic_wdata;
    logic [NCH-1:0] done_pulse = '0, berr_pulse = '0;
    logic [NCH-1:0] ic_berr, ch_busy, ch_en, ch_go;
    logic [NCH*3-1:0] ch_prio;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_base [NCH];
    logic [31:0] m_blk  [NCH];
    logic [31:0] m_ctl  [NCH];
    logic [31:0] m_pcr;

    always #4 clk = ~clk;

    dma_chan_regs u_dma_chan_regs (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ic_we(ic_we), .ic_wdata(ic_wdata), .ic_rdata(IRQ_WORD),
        .done_pulse(done_pulse), .berr_pulse(berr_pulse), .ic_berr(ic_berr),
        .ch_busy(ch_busy), .ch_en(ch_en), .ch_prio(ch_prio), .ch_go(ch_go)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] expect_rd(input logic [6:0] a);
        int ch = int'(a) / 16;
        int sl = int'(a) % 16;
        if (a[1:0] != 2'b00) return 32'h0;
        if (a == 7'h70) return m_pcr;
        if (a == 7'h74) return IRQ_WORD;
        if (ch >= NCH) return 32'h0;
        if (sl == 0) return m_base[ch];
        if (sl == 4) return m_blk[ch];
        if (sl == 8) return m_ctl[ch];
        return 32'h0;
    endfunction

    function automatic void model_wr(input logic [6:0] a, input logic [31:0] d);
        int ch = int'(a) / 16;
        int sl = int'(a) % 16;
        if (a[1:0] != 2'b00) return;
        if (a == 7'h70) begin m_pcr = d; return; end
        if (ch >= NCH) return;
        if (sl == 0) m_base[ch] = d;
        else if (sl == 4) m_blk[ch] = d;
        else if (sl == 8) m_ctl[ch] = d;
    endfunction

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        if (a == 7'h74) begin
            chk("R2 ic_we", {31'b0, ic_we}, 32'h1);
            chk("R2 ic_wdata", ic_wdata, d);
        end
        model_wr(a, d);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_outputs(input string tag);
        logic [NCH-1:0] eb, ee, eg;
        logic [NCH*3-1:0] ep;
        for (int i = 0; i < NCH; i++) begin
            eb[i] = m_ctl[i][BB];
            ee[i] = m_pcr[4*i+3];
            ep[3*i+:3] = m_pcr[4*i+:3];
            eg[i] = eb[i] & ee[i];
        end
        chk({"R5 busy ", tag}, 32'(ch_busy), 32'(eb));
        chk({"R4 en ", tag}, 32'(ch_en), 32'(ee));
        chk({"R4 prio ", tag}, 32'(ch_prio), 32'(ep));
        chk({"R5 go ", tag}, 32'(ch_go), 32'(eg));
    endtask

    task automatic sweep_read(input string tag);
        logic [31:0] d;
        for (int a = 0; a < 128; a += 4) begin
            bus_rd(7'(a), d);
            chk({tag, " R1/R2/R8 read"}, d, expect_rd(7'(a)));
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NCH; i++) begin
            m_base[i] = '0; m_blk[i] = '0; m_ctl[i] = '0;
        end
        m_pcr = 32'h0765_4321;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R3 reset image, R9 idle rdata
        chk("R9 idle rdata", bus_rdata, 32'h0);
        check_outputs("R3 reset");
        sweep_read("R3");

        // R1 R2 R8 full write sweep with distinct values
        for (int a = 0; a < 128; a += 4)
            bus_wr(7'(a), 32'h9E37_79B9 * 32'(a + 1));
        sweep_read("sweep");
        check_outputs("sweep");
        @(negedge clk);
        chk("R9 rdata zero after read", bus_rdata, 32'h0);

        // R8 misaligned offsets ignored
        for (int a = 1; a < 4; a++) begin
            bus_wr(7'(a), 32'hFFFF_FFFF);
            bus_rd(7'(a), d);
            chk("R8 misaligned read", d, 32'h0);
        end
        bus_rd(7'h00, d);
        chk("R8 base0 untouched", d, m_base[0]);

        // R4 R5 enable/busy patterns
        for (int p = 0; p < 4; p++) begin
            logic [31:0] pcr;
            pcr = 32'h0;
            for (int i = 0; i < NCH; i++)
                pcr[4*i+:4] = {((i + p) % 2 == 0) || (p == 3), 3'(i + p)};
            bus_wr(7'h70, pcr);
            for (int i = 0; i < NCH; i++)
                bus_wr(7'(16*i + 8), 32'h00AB_00CD | ((((i >> (p % 3)) & 1) != 0) ? 32'h0100_0000 : 32'h0));
            @(negedge clk);
            check_outputs($sformatf("pattern %0d", p));
        end

        // set all busy, enable all
        bus_wr(7'h70, 32'h0FFF_FFFF);
        for (int i = 0; i < NCH; i++) bus_wr(7'(16*i + 8), 32'h0100_0000 | 32'(i * 3 + 1));
        @(negedge clk);
        check_outputs("all busy");

        // R6 done pulse on channels 0,2
        @(negedge clk) done_pulse = 7'b0000101;
        @(negedge clk) done_pulse = '0;
        m_ctl[0][BB] = 1'b0; m_ctl[2][BB] = 1'b0;
        check_outputs("R6 done");
        bus_rd(7'h08, d);
        chk("R6 other bits kept", d, m_ctl[0]);

        // R7 bus error on channel 5
        @(negedge clk) berr_pulse = 7'b0100000;
        @(negedge clk) berr_pulse = '0;
        m_ctl[5][BB] = 1'b0;
        chk("R7 ic_berr pulse", 32'(ic_berr), 32'h20);
        check_outputs("R7 berr");
        @(negedge clk);
        chk("R7 ic_berr one cycle", 32'(ic_berr), 32'h0);

        // R7 idle channel: no state change beyond busy
        @(negedge clk) berr_pulse = 7'b0000001;
        @(negedge clk) berr_pulse = '0;
        chk("R7 ic_berr idle ch", 32'(ic_berr), 32'h1);
        check_outputs("R7 idle");

        // R6 done coincident with write setting busy
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 7'h38; bus_wdata = 32'h0100_BEEF;
        done_pulse = 7'b0001000;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; done_pulse = '0;
        m_ctl[3] = 32'h0000_BEEF;
        bus_rd(7'h38, d);
        chk("R6 clear beats write", d, 32'h0000_BEEF);
        check_outputs("R6 collide");

        // R2 interrupt write forwarded, nothing stored locally
        bus_wr(7'h74, 32'h1234_5678);
        sweep_read("after irq write");

        finish_run();
    end

endmodule